// File: doc/BRIEF.md
# Self-Test Loopback Controller

This block sits between the Manchester encoder, the two biphase line channels (A and B) and the two Manchester decoders of a dual-channel bus terminal. In normal operation it passes each line receiver to its decoder and the encoder symbol to each line driver, gated by per-channel receive and transmit enables held in a host-writable control register. When self-test is requested it wraps the encoder output back into one decoder and shuts off both line receivers, so the terminal can exercise its own transmit and receive paths without taking commands from the bus.

Self-test can be requested in two ways. A dedicated test pin requests external test; the channel is then taken from a companion channel-select pin, and the looped-back traffic also goes out on the selected line driver. Setting the test-enable bit of the control register requests internal test; the channel is then taken from the register's channel-select bit, and both line drivers stay silent. The test mode and the selected channel are resolved into a register, so a change on the pins or in the control register reaches the routing only at a clock edge. The test and channel-select pins are assumed to be already synchronous to the block clock.

Top module: `stl_loopback_top`

## Requirements
- R1: After a synchronous reset the control register is all zeros and the mode is normal, so all four data outputs (both decoder inputs and both line outputs) are zero.
- R2: A write stores `cfg_wdata_i` in the control register at the clock edge where `cfg_wr_i` is high; the mode derived from the new value appears one clock edge later, so in the cycle after the write the routing still follows the previous mode.
- R3: Self-test is active when `ext_test_i` is 1 (external mode) or when control bit 7 is 1 (internal mode); when both hold, the pin wins and the mode is external.
- R4: The selected channel is 0 for A and 1 for B; in external mode it comes from `ext_chsel_i`, in internal mode from control bit 6.
- R5: During either self-test mode the decoder input of the selected channel equals `enc_sym_i`.
- R6: During either self-test mode the decoder input of the other channel is zero, and neither line receiver input reaches a decoder.
- R7: In external mode the selected channel's line output equals `enc_sym_i` and the other line output is zero.
- R8: In internal mode both line outputs are zero.
- R9: In normal mode each decoder input equals its line receiver input when its receive enable is 1 and is zero otherwise (A: bit 0, B: bit 1); each line output equals `enc_sym_i` when its transmit enable is 1 and is zero otherwise (A: bit 2, B: bit 3).
- R10: During self-test the four channel-enable bits (bits 0 to 3) have no effect on any output.
- R11: A change of `ext_test_i` or `ext_chsel_i` changes the routing only after the next clock edge, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_test_i | input | 1 | Test request pin (external mode) |
| ext_chsel_i | input | 1 | Channel-select pin, 0 = A, 1 = B |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| enc_sym_i | input | SYM_W | Symbol from the Manchester encoder |
| rx_line_a_i | input | SYM_W | Line receiver symbol, channel A |
| rx_line_b_i | input | SYM_W | Line receiver symbol, channel B |
| dec_in_a_o | output | SYM_W | Decoder A input |
| dec_in_b_o | output | SYM_W | Decoder B input |
| tx_line_a_o | output | SYM_W | Line driver symbol, channel A |
| tx_line_b_o | output | SYM_W | Line driver symbol, channel B |

## Verification
The bench builds the block with SYM_W = 4 rather than the default 2, so that a random encoder symbol and the two random line receiver symbols almost never coincide and a decoder fed from the wrong source, or a line gated on when it should be idle, shows up as a value mismatch within a few cycles. Directed sequences walk through register writes, internal test on each channel, the pin overriding the register and both selects, followed by a long random mix of pin toggles and control writes that lands writes and pin edges on adjacent cycles to probe the one-edge latency.

// File: rtl/stl_pkg.sv
package stl_pkg;

    // Control register layout; bits 7 and 6 steer the self-test routing.
    localparam int CFG_W        = 8;
    localparam int NCH          = 2;
    localparam int BIT_TEST     = 7;
    localparam int BIT_CHSEL    = 6;
    localparam int BIT_TXEN_LO  = 2;
    localparam int BIT_RXEN_LO  = 0;
    localparam int RSVD_LO      = BIT_TXEN_LO + NCH;
    localparam int RSVD_HI      = BIT_CHSEL - 1;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_INT    = 2'd1,
        MODE_EXT    = 2'd2
    } st_mode_e;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } ch_sel_e;

    typedef struct packed {
        logic           test_en;
        logic           chan_sel;
        logic [NCH-1:0] tx_en;
        logic [NCH-1:0] rx_en;
    } ctl_t;

    typedef struct packed {
        st_mode_e mode;
        ch_sel_e  chan;
    } route_t;

    localparam route_t ROUTE_RESET = '{mode: MODE_NORMAL, chan: CH_A};

    // Pin request outranks the register request.
    function automatic route_t resolve_route(input logic pin_test,
                                             input logic pin_ch,
                                             input ctl_t c);
        route_t r;
        if (pin_test) begin
            r.mode = MODE_EXT;
            r.chan = ch_sel_e'(pin_ch);
        end else if (c.test_en) begin
            r.mode = MODE_INT;
            r.chan = ch_sel_e'(c.chan_sel);
        end else begin
            r = ROUTE_RESET;
        end
        return r;
    endfunction

    function automatic logic chan_hit(input route_t r, input int idx);
        return (int'(r.chan) == idx);
    endfunction

endpackage

// File: rtl/stl_ctl_reg.sv
module stl_ctl_reg
    import stl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output ctl_t             ctl_q
);

    ctl_t ctl_d;
    logic unused_rsvd_bits;

    always_comb begin
        ctl_d.test_en  = wr_data[BIT_TEST];
        ctl_d.chan_sel = wr_data[BIT_CHSEL];
        ctl_d.tx_en    = wr_data[BIT_TXEN_LO +: NCH];
        ctl_d.rx_en    = wr_data[BIT_RXEN_LO +: NCH];
    end

    assign unused_rsvd_bits = ^wr_data[RSVD_HI:RSVD_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/stl_mode_ctrl.sv
module stl_mode_ctrl
    import stl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_test,
    input  logic   pin_ch,
    input  ctl_t   ctl,
    output route_t route_q
);

    route_t route_d;

    always_comb begin
        route_d = resolve_route(pin_test, pin_ch, ctl);
    end

    // Registered so that the data muxes only switch on a clock edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_RESET;
        end else begin
            route_q <= route_d;
        end
    end

endmodule

// File: rtl/stl_route.sv
module stl_route
    import stl_pkg::*;
#(
    parameter int SYM_W = 2
) (
    input  route_t                        route,
    input  logic [NCH-1:0]                rx_en,
    input  logic [NCH-1:0]                tx_en,
    input  logic [SYM_W-1:0]              enc_sym,
    input  logic [NCH-1:0][SYM_W-1:0]     rx_sym,
    output logic [NCH-1:0][SYM_W-1:0]     dec_sym,
    output logic [NCH-1:0][SYM_W-1:0]     tx_sym
);

    localparam logic [SYM_W-1:0] IDLE = '0;

    logic testing;
    assign testing = (route.mode != MODE_NORMAL);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic             sel;
        logic [SYM_W-1:0] dec_v;
        logic [SYM_W-1:0] tx_v;

        assign sel = chan_hit(route, ch);

        always_comb begin
            if (testing) begin
                dec_v = sel ? enc_sym : IDLE;
            end else begin
                dec_v = rx_en[ch] ? rx_sym[ch] : IDLE;
            end
        end

        always_comb begin
            unique case (route.mode)
                MODE_EXT: tx_v = sel ? enc_sym : IDLE;
                MODE_INT: tx_v = IDLE;
                default:  tx_v = tx_en[ch] ? enc_sym : IDLE;
            endcase
        end

        assign dec_sym[ch] = dec_v;
        assign tx_sym[ch]  = tx_v;
    end

endmodule

// File: rtl/stl_loopback_top.sv
module stl_loopback_top
    import stl_pkg::*;
#(
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_test_i,
    input  logic             ext_chsel_i,
    input  logic             cfg_wr_i,
    input  logic [7:0]       cfg_wdata_i,
    input  logic [SYM_W-1:0] enc_sym_i,
    input  logic [SYM_W-1:0] rx_line_a_i,
    input  logic [SYM_W-1:0] rx_line_b_i,
    output logic [SYM_W-1:0] dec_in_a_o,
    output logic [SYM_W-1:0] dec_in_b_o,
    output logic [SYM_W-1:0] tx_line_a_o,
    output logic [SYM_W-1:0] tx_line_b_o
);

    ctl_t                     ctl_q;
    route_t                   route_q;
    logic [NCH-1:0][SYM_W-1:0] rx_vec;
    logic [NCH-1:0][SYM_W-1:0] dec_vec;
    logic [NCH-1:0][SYM_W-1:0] tx_vec;

    stl_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_i),
        .wr_data (cfg_wdata_i),
        .ctl_q   (ctl_q)
    );

    stl_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .pin_test (ext_test_i),
        .pin_ch   (ext_chsel_i),
        .ctl      (ctl_q),
        .route_q  (route_q)
    );

    assign rx_vec[0] = rx_line_a_i;
    assign rx_vec[1] = rx_line_b_i;

    stl_route #(.SYM_W(SYM_W)) u_route (
        .route   (route_q),
        .rx_en   (ctl_q.rx_en),
        .tx_en   (ctl_q.tx_en),
        .enc_sym (enc_sym_i),
        .rx_sym  (rx_vec),
        .dec_sym (dec_vec),
        .tx_sym  (tx_vec)
    );

    assign dec_in_a_o  = dec_vec[0];
    assign dec_in_b_o  = dec_vec[1];
    assign tx_line_a_o = tx_vec[0];
    assign tx_line_b_o = tx_vec[1];

endmodule

// File: rtl/stl_loopback_chk.sv
module stl_loopback_chk
    import stl_pkg::*;
#(
    parameter int SYM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_test_i,
    input logic [SYM_W-1:0] enc_sym_i,
    input logic [SYM_W-1:0] dec_in_a_o,
    input logic [SYM_W-1:0] dec_in_b_o,
    input logic [SYM_W-1:0] tx_line_a_o,
    input logic [SYM_W-1:0] tx_line_b_o,
    input route_t           route_q,
    input ctl_t             ctl_q
);

    // R11
    pin_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ext_test_i |=> (route_q.mode == MODE_EXT));

    // R3
    reg_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_test_i && ctl_q.test_en) |=> (route_q.mode == MODE_INT));

    // R8
    int_tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q.mode == MODE_INT) |-> (tx_line_a_o == '0 && tx_line_b_o == '0));

    // R7
    ext_tx_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q.mode == MODE_EXT) |->
            ((route_q.chan == CH_A) ? (tx_line_a_o == enc_sym_i && tx_line_b_o == '0)
                                    : (tx_line_b_o == enc_sym_i && tx_line_a_o == '0)));

    // R5
    loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q.mode != MODE_NORMAL) |->
            ((route_q.chan == CH_A) ? (dec_in_a_o == enc_sym_i) : (dec_in_b_o == enc_sym_i)));

    // R6
    idle_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q.mode != MODE_NORMAL) |->
            ((route_q.chan == CH_A) ? (dec_in_b_o == '0) : (dec_in_a_o == '0)));

    // R9
    normal_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q.mode == MODE_NORMAL && !ctl_q.rx_en[0]) |-> (dec_in_a_o == '0));

endmodule

bind stl_loopback_top stl_loopback_chk #(.SYM_W(SYM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_test_i  (ext_test_i),
    .enc_sym_i   (enc_sym_i),
    .dec_in_a_o  (dec_in_a_o),
    .dec_in_b_o  (dec_in_b_o),
    .tx_line_a_o (tx_line_a_o),
    .tx_line_b_o (tx_line_b_o),
    .route_q     (route_q),
    .ctl_q       (ctl_q)
);

// File: tb/sim_stl_loopback_top.sv
`timescale 1ns/1ps
module sim_stl_loopback_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_test = 1'b0;
    logic         ext_chsel = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [7:0]   cfg_wdata = '0;
    logic [W-1:0] enc = '0;
    logic [W-1:0] rxa = '0;
    logic [W-1:0] rxb = '0;
    logic [W-1:0] dec_a, dec_b, tx_a, tx_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    stl_loopback_top #(.SYM_W(W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .ext_test_i  (ext_test),
        .ext_chsel_i (ext_chsel),
        .cfg_wr_i    (cfg_wr),
        .cfg_wdata_i (cfg_wdata),
        .enc_sym_i   (enc),
        .rx_line_a_i (rxa),
        .rx_line_b_i (rxb),
        .dec_in_a_o  (dec_a),
        .dec_in_b_o  (dec_b),
        .tx_line_a_o (tx_a),
        .tx_line_b_o (tx_b)
    );

    // Behavioural reference: mode 0 normal, 1 internal, 2 external.
    logic [7:0] m_cfg = '0;
    int         m_mode = 0;
    int         m_chan = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg  <= '0;
            m_mode <= 0;
            m_chan <= 0;
        end else begin
            if (cfg_wr) m_cfg <= cfg_wdata;
            if (ext_test) begin
                m_mode <= 2;
                m_chan <= int'(ext_chsel);
            end else if (m_cfg[7]) begin
                m_mode <= 1;
                m_chan <= int'(m_cfg[6]);
            end else begin
                m_mode <= 0;
                m_chan <= 0;
            end
        end
    end

    function automatic logic [W-1:0] exp_dec(input int ch);
        if (m_mode != 0) return (ch == m_chan) ? enc : '0;
        if (m_cfg[ch]) return (ch == 0) ? rxa : rxb;
        return '0;
    endfunction

    function automatic logic [W-1:0] exp_tx(input int ch);
        if (m_mode == 2) return (ch == m_chan) ? enc : '0;
        if (m_mode == 1) return '0;
        return m_cfg[2 + ch] ? enc : '0;
    endfunction

    task automatic cmp(input string tag, input string nm,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string td, tt;
        for (int ch = 0; ch < 2; ch++) begin
            if (m_mode != 0) td = (ch == m_chan) ? "R5" : "R6";
            else             td = "R9";
            if (m_mode == 2)      tt = "R7";
            else if (m_mode == 1) tt = "R8";
            else                  tt = "R9";
            cmp(td, (ch == 0) ? "dec_a" : "dec_b", (ch == 0) ? dec_a : dec_b, exp_dec(ch));
            cmp(tt, (ch == 0) ? "tx_a" : "tx_b", (ch == 0) ? tx_a : tx_b, exp_tx(ch));
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic new_data();
        enc = W'($urandom);
        rxa = W'($urandom);
        rxb = W'($urandom);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            new_data();
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        step();
        cfg_wr    = 1'b0;
    endtask

    initial begin
        new_data();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R1: reset leaves everything gated off
        cmp("R1", "dec_a", dec_a, '0);
        cmp("R1", "dec_b", dec_b, '0);
        cmp("R1", "tx_a", tx_a, '0);
        cmp("R1", "tx_b", tx_b, '0);
        new_data();

        write_cfg(8'h0F); new_data(); run(20);
        write_cfg(8'h05); new_data(); run(10);

        // R2: register updated, mode still normal for one cycle
        write_cfg(8'h8F);
        cmp("R2", "dec_b", dec_b, rxb);
        cmp("R2", "tx_a", tx_a, enc);
        new_data();
        step();
        cmp("R3", "dec_a", dec_a, enc);
        cmp("R10", "dec_b", dec_b, '0);
        cmp("R8", "tx_a", tx_a, '0);
        new_data(); run(20);

        write_cfg(8'hCF); new_data(); step();
        cmp("R4", "dec_b", dec_b, enc);
        cmp("R4", "dec_a", dec_a, '0);
        new_data(); run(10);

        write_cfg(8'hC0); new_data(); step();
        cmp("R10", "dec_b", dec_b, enc);
        cmp("R8", "tx_b", tx_b, '0);
        new_data(); run(10);

        // R11: pin change must not act before the edge
        ext_test  = 1'b1;
        ext_chsel = 1'b0;
        #1;
        cmp("R11", "dec_b", dec_b, enc);
        cmp("R11", "dec_a", dec_a, '0);
        step();
        cmp("R4", "dec_a", dec_a, enc);
        cmp("R7", "tx_a", tx_a, enc);
        cmp("R10", "tx_b", tx_b, '0);
        new_data(); run(10);

        ext_chsel = 1'b1; new_data(); run(10);
        write_cfg(8'h0A); new_data(); run(10);
        ext_test = 1'b0; new_data(); run(10);

        for (int i = 0; i < 400; i++) begin
            step();
            new_data();
            if ($urandom_range(0, 5) == 0) ext_test = ~ext_test;
            ext_chsel = 1'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                cfg_wr    = 1'b1;
                cfg_wdata = 8'($urandom);
            end else begin
                cfg_wr = 1'b0;
            end
        end
        cfg_wr = 1'b0;
        run(5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule